// File: doc/BRIEF.md
# Branch-Folding Predecoded Instruction Cache

This block is the fetch-side instruction store of a pipelined core. It is a small direct-mapped cache whose lines hold a predecoded instruction word together with the address to fetch after it. The fetch program counter is loaded straight from the line that hits, so no incrementer or separate target adder sits in the next-PC loop. The only extra logic on that path is the choice between the line's next field and the fall-through held for a mispredicted branch.

Control transfers are folded while a line is filled. A jump, call or conditional branch that follows an ordinary instruction is absorbed into that instruction's line. The host line then points at the control target, and the control word itself never appears as a fetch beat. A folded call raises a flag on the host beat, because the link register still has to be written and that write is extra. A folded branch is predicted taken. The host line keeps the fall-through address and the tested register. One cycle after the host beat is accepted, the execute side reports the real outcome. A not-taken result discards the already fetched target and steers fetch to the fall-through address.

Fetch beats leave on a valid/ready stream. While `fetch_valid` is high and `fetch_ready` is low, the beat and its fields are held. Misses are refilled through a request stream (`req_valid`/`req_ready`, one word per accepted address) and a response stream (`rsp_valid`/`rsp_ready`). At most one request is outstanding at a time, and each response answers the last accepted request. Resolve, squash and flush are plain control pins.

Top module: `fold_icache`

## Requirements
- R1: While reset is applied, `fetch_valid`, `req_valid` and `squash` are low. After reset, the first refill request is for address `RESET_PC`.
- R2: A miss at address A issues a refill request for A. If the word returned for A is not a control word, a second request for A+4 follows. Every requested address is word aligned.
- R3: Instruction words carry the opcode in bits [31:26]. Opcode 2 is a jump, 3 is a call and 4 is a branch; any other opcode is an ordinary word. If neither A nor A+4 holds a control word, the beat at A reports kind 0, its own word, and is followed by the beat at A+4.
- R4: If the word at A+4 is a jump with target {bits[25:0],00}, the beat at A reports kind 1 and is followed directly by the target. No beat is ever presented for A+4.
- R5: A call at A+4 (same target field) is folded the same way. The beat at A reports kind 2, raises `fetch_link_wr`, and gives the return address A+8 on `fetch_alt_pc`.
- R6: A branch at A+4 has its target in {bits[15:0],00} and its tested register in bits[25:21]. The beat at A reports kind 3, the register on `fetch_cond_reg` and the fall-through A+8 on `fetch_alt_pc`. It is followed by the branch target.
- R7: A resolve arrives in the cycle after a kind-3 beat is accepted. If the branch was not taken, `squash` is high for exactly that cycle, no beat is offered in that cycle, and the next beat is the fall-through address. If it was taken, `squash` stays low and the target beat proceeds.
- R8: A control word at the fetched address itself is hosted by its own line with the same kind, target and alternate rules, using A+4 as the fall-through or return address. Only one refill request is made for that line.
- R9: A beat that is offered and not accepted keeps the same address and word until it is accepted. A refill request that is not accepted keeps its address.
- R10: `flush` invalidates every line in one cycle. No beat is offered in the next cycle, and the current address is then fetched again from memory.
- R11: Once every reachable line is resident, no refill requests are made. A beat is offered in every cycle that is not a squash cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines |
| fetch_valid | output | 1 | Fetch beat offered |
| fetch_ready | input | 1 | Downstream accepts the beat |
| fetch_pc | output | ADDR_W | Address of the offered instruction |
| fetch_word | output | 32 | Instruction word |
| fetch_kind | output | 2 | Folded control kind: 0 none, 1 jump, 2 call, 3 branch |
| fetch_alt_pc | output | ADDR_W | Branch fall-through or call return address |
| fetch_cond_reg | output | 5 | Register tested by a folded branch |
| fetch_link_wr | output | 1 | Pending extra link-register write for a folded call |
| res_valid | input | 1 | Branch outcome is present |
| res_taken | input | 1 | Branch was taken |
| squash | output | 1 | Predicted target discarded this cycle |
| req_valid | output | 1 | Refill request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Word address requested |
| rsp_valid | input | 1 | Refill word valid |
| rsp_ready | output | 1 | Cache accepts the refill word |
| rsp_word | input | 32 | Refill word |

## Verification
The hardest case to reach from the ports is a mispredicted branch. The resolve has to land in the one cycle after the host beat is accepted, while downstream back-pressure, a refill in flight and a possible miss on the predicted target all interact with it. The stimulus runs a looping program that contains every folding form and a self-hosted jump. It answers branch outcomes alternately, so both the taken and the fall-through path are walked repeatedly. Pseudo-random ready patterns are applied on both the fetch and the refill side. A flush in the middle of the run forces the refill and squash sequences to happen again on a cold cache.

// File: rtl/fic_pkg.sv
package fic_pkg;

  localparam logic [5:0] OPC_JUMP = 6'h02;
  localparam logic [5:0] OPC_CALL = 6'h03;
  localparam logic [5:0] OPC_BNZ  = 6'h04;

  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_JUMP   = 2'd1,
    K_CALL   = 2'd2,
    K_BRANCH = 2'd3
  } fold_kind_e;

  function automatic fold_kind_e kind_of(input logic [31:0] w);
    case (w[31:26])
      OPC_JUMP: return K_JUMP;
      OPC_CALL: return K_CALL;
      OPC_BNZ:  return K_BRANCH;
      default:  return K_NONE;
    endcase
  endfunction

  function automatic logic [31:0] target_of(input logic [31:0] w);
    if (w[31:26] == OPC_BNZ) return {14'd0, w[15:0], 2'b00};
    return {4'd0, w[25:0], 2'b00};
  endfunction

endpackage

// File: rtl/fic_fold.sv
module fic_fold
  import fic_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_word,
  input  logic [31:0]       succ_word,
  output fold_kind_e        kind,
  output logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] alt_addr,
  output logic [4:0]        cond_reg
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  fold_kind_e        host_k;
  fold_kind_e        succ_k;
  logic [ADDR_W-1:0] ctl_addr;
  logic [31:0]       ctl_word;

  always_comb begin
    host_k   = kind_of(host_word);
    succ_k   = kind_of(succ_word);
    // A control word at the host address hosts itself; otherwise the
    // successor word may be folded into the host line.
    ctl_addr = host_addr;
    ctl_word = host_word;
    kind     = host_k;
    if (host_k == K_NONE) begin
      ctl_addr = host_addr + STEP;
      ctl_word = succ_word;
      kind     = succ_k;
    end
    alt_addr  = ctl_addr + STEP;
    next_addr = (kind == K_NONE) ? ctl_addr : ADDR_W'(target_of(ctl_word));
    cond_reg  = (kind == K_BRANCH) ? ctl_word[25:21] : 5'd0;
  end

endmodule

// File: rtl/fic_lines.sv
module fic_lines
  import fic_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic [31:0]       rd_word,
  output fold_kind_e        rd_kind,
  output logic [ADDR_W-1:0] rd_next,
  output logic [ADDR_W-1:0] rd_alt,
  output logic [4:0]        rd_creg,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_word,
  input  fold_kind_e        wr_kind,
  input  logic [ADDR_W-1:0] wr_next,
  input  logic [ADDR_W-1:0] wr_alt,
  input  logic [4:0]        wr_creg
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_W = ADDR_W - IDX_W - 2;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [31:0]       word;
    fold_kind_e        kind;
    logic [ADDR_W-1:0] next;
    logic [ADDR_W-1:0] alt;
    logic [4:0]        creg;
  } line_t;

  line_t             line_q [DEPTH];
  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  valid_d;
  logic [DEPTH-1:0]  line_wr;
  logic [IDX_W-1:0]  widx;
  logic [IDX_W-1:0]  ridx;
  line_t             wr_line;
  line_t             rd_line;

  assign widx = wr_addr[IDX_W+1:2];
  assign ridx = rd_addr[IDX_W+1:2];

  always_comb begin
    wr_line.tag  = wr_addr[ADDR_W-1:IDX_W+2];
    wr_line.word = wr_word;
    wr_line.kind = wr_kind;
    wr_line.next = wr_next;
    wr_line.alt  = wr_alt;
    wr_line.creg = wr_creg;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_line
    assign line_wr[g] = wr_en && (widx == IDX_W'(g));
    assign valid_d[g] = flush ? 1'b0 : (valid_q[g] | line_wr[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (line_wr[i]) line_q[i] <= wr_line;
    end
  end

  assign rd_line = line_q[ridx];
  assign rd_hit  = valid_q[ridx] && (rd_line.tag == rd_addr[ADDR_W-1:IDX_W+2]);
  assign rd_word = rd_line.word;
  assign rd_kind = rd_line.kind;
  assign rd_next = rd_line.next;
  assign rd_alt  = rd_line.alt;
  assign rd_creg = rd_line.creg;

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rd_hit);

endmodule

// File: rtl/fic_refill.sv
module fic_refill
  import fic_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_word,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_base,
  output logic [31:0]       wr_host,
  output logic [31:0]       wr_succ
);

  typedef enum logic [2:0] {
    F_IDLE, F_REQ0, F_RSP0, F_REQ1, F_RSP1
  } fill_st_e;

  fill_st_e          st_q;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       w0_q;
  logic              stale_q;
  logic              last_beat;

  assign busy      = (st_q != F_IDLE);
  assign req_valid = (st_q == F_REQ0) || (st_q == F_REQ1);
  assign req_addr  = (st_q == F_REQ1) ? base_q + ADDR_W'(4) : base_q;
  assign rsp_ready = (st_q == F_RSP0) || (st_q == F_RSP1);

  // The fill ends early when the first word is itself a control word.
  assign last_beat = rsp_valid &&
                     (((st_q == F_RSP0) && (kind_of(rsp_word) != K_NONE)) ||
                      (st_q == F_RSP1));

  assign wr_en   = last_beat && !stale_q && !flush;
  assign wr_base = base_q;
  assign wr_host = (st_q == F_RSP0) ? rsp_word : w0_q;
  assign wr_succ = (st_q == F_RSP1) ? rsp_word : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= F_IDLE;
      base_q  <= '0;
      w0_q    <= '0;
      stale_q <= 1'b0;
    end else begin
      if (flush && busy) stale_q <= 1'b1;
      case (st_q)
        F_IDLE: if (start) begin
          st_q    <= F_REQ0;
          base_q  <= start_addr;
          stale_q <= 1'b0;
        end
        F_REQ0: if (req_ready) st_q <= F_RSP0;
        F_RSP0: if (rsp_valid) begin
          w0_q <= rsp_word;
          st_q <= last_beat ? F_IDLE : F_REQ1;
        end
        F_REQ1: if (req_ready) st_q <= F_RSP1;
        F_RSP1: if (rsp_valid) st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  // R2
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[1:0] == 2'b00);

endmodule

// File: rtl/fold_icache.sv
module fold_icache
  import fic_pkg::*;
#(
  parameter int                DEPTH    = 16,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic [31:0]       fetch_word,
  output logic [1:0]        fetch_kind,
  output logic [ADDR_W-1:0] fetch_alt_pc,
  output logic [4:0]        fetch_cond_reg,
  output logic              fetch_link_wr,
  input  logic              res_valid,
  input  logic              res_taken,
  output logic              squash,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_word
);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] fall_q;
  logic              hit;
  logic [31:0]       rd_word;
  fold_kind_e        rd_kind;
  logic [ADDR_W-1:0] rd_next;
  logic [ADDR_W-1:0] rd_alt;
  logic [4:0]        rd_creg;
  logic              busy;
  logic              start;
  logic              accept;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_base;
  logic [31:0]       wr_host;
  logic [31:0]       wr_succ;
  fold_kind_e        f_kind;
  logic [ADDR_W-1:0] f_next;
  logic [ADDR_W-1:0] f_alt;
  logic [4:0]        f_creg;

  assign squash      = res_valid && !res_taken;
  assign fetch_valid = hit && !busy && !squash;
  assign accept      = fetch_valid && fetch_ready;
  assign start       = !hit && !busy && !squash && !flush;

  assign fetch_pc       = pc_q;
  assign fetch_word     = rd_word;
  assign fetch_kind     = rd_kind;
  assign fetch_alt_pc   = rd_alt;
  assign fetch_cond_reg = rd_creg;
  assign fetch_link_wr  = fetch_valid && (rd_kind == K_CALL);

  // The next PC is taken from the line, or from the held fall-through.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      fall_q <= '0;
    end else begin
      if (squash)      pc_q <= fall_q;
      else if (accept) pc_q <= rd_next;
      if (accept && rd_kind == K_BRANCH) fall_q <= rd_alt;
    end
  end

  fic_lines #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .rd_addr (pc_q),
    .rd_hit  (hit),
    .rd_word (rd_word),
    .rd_kind (rd_kind),
    .rd_next (rd_next),
    .rd_alt  (rd_alt),
    .rd_creg (rd_creg),
    .wr_en   (wr_en),
    .wr_addr (wr_base),
    .wr_word (wr_host),
    .wr_kind (f_kind),
    .wr_next (f_next),
    .wr_alt  (f_alt),
    .wr_creg (f_creg)
  );

  fic_refill #(.ADDR_W(ADDR_W)) u_refill (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .start      (start),
    .start_addr (pc_q),
    .busy       (busy),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_word   (rsp_word),
    .wr_en      (wr_en),
    .wr_base    (wr_base),
    .wr_host    (wr_host),
    .wr_succ    (wr_succ)
  );

  fic_fold #(.ADDR_W(ADDR_W)) u_fold (
    .host_addr (wr_base),
    .host_word (wr_host),
    .succ_word (wr_succ),
    .kind      (f_kind),
    .next_addr (f_next),
    .alt_addr  (f_alt),
    .cond_reg  (f_creg)
  );

  // R7
  squash_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !squash);

  // R7
  resolve_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(fetch_valid && fetch_ready && fetch_kind == 2'd3));

  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready && !flush |=>
      fetch_valid && $stable(fetch_pc) && $stable(fetch_word));

  // R10
  flush_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !fetch_valid);

endmodule

// File: tb/sim_fold_icache.sv
`timescale 1ns/1ps
module sim_fold_icache;

  localparam int AW       = 16;
  localparam int DEP      = 16;
  localparam int N_CYC    = 3000;
  localparam int FLUSH_AT = 1500;
  localparam int WARM_LO  = 800;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flush;
  logic          fetch_valid, fetch_ready;
  logic [AW-1:0] fetch_pc;
  logic [31:0]   fetch_word;
  logic [1:0]    fetch_kind;
  logic [AW-1:0] fetch_alt_pc;
  logic [4:0]    fetch_cond_reg;
  logic          fetch_link_wr;
  logic          res_valid, res_taken, squash;
  logic          req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic          rsp_valid, rsp_ready;
  logic [31:0]   rsp_word;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #2 clk = ~clk;

  fold_icache #(.DEPTH(DEP), .ADDR_W(AW), .RESET_PC(16'h0000)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_pc(fetch_pc),
    .fetch_word(fetch_word), .fetch_kind(fetch_kind), .fetch_alt_pc(fetch_alt_pc),
    .fetch_cond_reg(fetch_cond_reg), .fetch_link_wr(fetch_link_wr),
    .res_valid(res_valid), .res_taken(res_taken), .squash(squash),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_word(rsp_word)
  );

  // Program: 00 04 [08 jump->14] 14 [18 call->24] 1C 20 24 [28 branch r5->00]
  //          2C [30 jump->3C] 3C: self-hosted jump->1C
  function automatic logic [31:0] mem(input logic [AW-1:0] a);
    case (a)
      16'h0008: return {6'h02, 26'(16'h0014 >> 2)};
      16'h0018: return {6'h03, 26'(16'h0024 >> 2)};
      16'h0028: return {6'h04, 5'd5, 5'd0, 16'h0000};
      16'h0030: return {6'h02, 26'(16'h003C >> 2)};
      16'h003C: return {6'h02, 26'(16'h001C >> 2)};
      default:  return {6'h00, 10'h000, a};
    endcase
  endfunction

  function automatic int kind_w(input logic [31:0] w);
    if (w[31:26] == 6'd2) return 1;
    if (w[31:26] == 6'd3) return 2;
    if (w[31:26] == 6'd4) return 3;
    return 0;
  endfunction

  function automatic logic [AW-1:0] tgt_w(input logic [31:0] w);
    if (w[31:26] == 6'd4) return AW'(w[15:0]) << 2;
    return AW'(w[25:0]) << 2;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] exp_pc, exp_fall, rsp_addr_q;
    logic [15:0]   lfsr;
    bit            br_acc, take_pend, take_tog, rsp_pend, first_req, post_flush_req;
    int            warm_reqs, post_reqs, squashes, links, selfs;

    rst_n = 1'b0; flush = 1'b0; fetch_ready = 1'b0; res_valid = 1'b0;
    res_taken = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0; rsp_word = '0;
    exp_pc = '0; exp_fall = '0; rsp_addr_q = '0; lfsr = 16'hACE1;
    br_acc = 0; take_pend = 0; take_tog = 0; rsp_pend = 0;
    first_req = 1; post_flush_req = 0;
    warm_reqs = 0; post_reqs = 0; squashes = 0; links = 0; selfs = 0;

    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!fetch_valid && !req_valid && !squash, "R1 reset outputs",
        {29'd0, fetch_valid, req_valid, squash}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int c = 0; c < N_CYC; c++) begin
      @(negedge clk);
      res_valid = br_acc;
      res_taken = take_pend;
      br_acc    = 0;
      flush     = (c == FLUSH_AT);
      rsp_valid = rsp_pend;
      rsp_word  = mem(rsp_addr_q);
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fetch_ready = lfsr[0] | lfsr[3];
      req_ready   = lfsr[5] | lfsr[7];
      #1;

      // R7 outcome handling
      if (res_valid && !res_taken) begin
        chk(squash && !fetch_valid, "R7 squash on not-taken",
            {30'd0, squash, fetch_valid}, 32'd2);
        exp_pc = exp_fall;
        squashes++;
      end else begin
        chk(!squash, "R7 no squash", {31'd0, squash}, 32'd0);
      end

      // R10 blank cycle after flush
      if (c == FLUSH_AT + 1)
        chk(!fetch_valid, "R10 no beat after flush", {31'd0, fetch_valid}, 32'd0);

      // R11 warm cache: a beat every non-squash cycle, no refills
      if (c >= WARM_LO && c < FLUSH_AT) begin
        if (req_valid) warm_reqs++;
        if (!(res_valid && !res_taken))
          chk(fetch_valid, "R11 beat every cycle when warm", {31'd0, fetch_valid}, 32'd1);
      end
      if (c == FLUSH_AT - 1)
        chk(warm_reqs == 0, "R11 no refill when warm", 32'(warm_reqs), 32'd0);

      // R2 / R1 / R10 refill addresses
      if (req_valid) begin
        if (first_req) begin
          chk(req_addr == 16'h0000, "R1 first request at reset pc", 32'(req_addr), 32'd0);
          first_req = 0;
        end
        if (post_flush_req) begin
          chk(req_addr == exp_pc, "R10 refetch after flush", 32'(req_addr), 32'(exp_pc));
          post_flush_req = 0;
        end
        chk(req_addr == exp_pc || req_addr == exp_pc + 16'd4, "R2 request address",
            32'(req_addr), 32'(exp_pc));
        if (c > FLUSH_AT && req_ready) post_reqs++;
      end
      if (c == FLUSH_AT) post_flush_req = 1;

      // R3-R6, R8 beat contents against the program model
      if (fetch_valid && fetch_ready) begin
        logic [31:0]   hw, cw;
        logic [AW-1:0] ca;
        int            k;
        string         tag;
        hw = mem(exp_pc);
        k  = kind_w(hw);
        ca = exp_pc;
        cw = hw;
        tag = "R8";
        if (k == 0) begin
          ca = exp_pc + 16'd4;
          cw = mem(ca);
          k  = kind_w(cw);
          tag = (k == 0) ? "R3" : (k == 1) ? "R4" : (k == 2) ? "R5" : "R6";
        end else selfs++;
        chk(fetch_pc == exp_pc, {tag, " beat address"}, 32'(fetch_pc), 32'(exp_pc));
        chk(fetch_word == hw, {tag, " beat word"}, fetch_word, hw);
        chk(32'(fetch_kind) == 32'(k), {tag, " beat kind"}, 32'(fetch_kind), 32'(k));
        chk(fetch_link_wr == (k == 2), "R5 link write flag",
            {31'd0, fetch_link_wr}, {31'd0, k == 2});
        if (k != 0)
          chk(fetch_alt_pc == ca + 16'd4, {tag, " alternate address"},
              32'(fetch_alt_pc), 32'(ca + 16'd4));
        if (k == 3)
          chk(fetch_cond_reg == cw[25:21], "R6 tested register",
              32'(fetch_cond_reg), 32'(cw[25:21]));
        if (k == 2) links++;
        if (k == 0) exp_pc = exp_pc + 16'd4;
        else        exp_pc = tgt_w(cw);
        if (k == 3) begin
          br_acc    = 1;
          exp_fall  = ca + 16'd4;
          take_pend = take_tog;
          take_tog  = ~take_tog;
        end
      end else if (fetch_valid) begin
        chk(fetch_pc == exp_pc, "R9 held beat address", 32'(fetch_pc), 32'(exp_pc));
      end

      if (rsp_valid && rsp_ready) rsp_pend = 0;
      if (req_valid && req_ready) begin
        rsp_pend   = 1;
        rsp_addr_q = req_addr;
      end
    end

    chk(squashes > 4, "R7 squashes occurred", 32'(squashes), 32'd5);
    chk(links > 4, "R5 folded calls issued", 32'(links), 32'd5);
    chk(selfs > 2, "R8 self-hosted jumps issued", 32'(selfs), 32'd3);
    chk(post_reqs > 0, "R10 refills after flush", 32'(post_reqs), 32'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule